// File: doc/BRIEF.md
# Escape Mode Lane Receiver

This block watches the two single-ended low-power levels of one serial data lane and recovers escape-mode traffic from them. It runs in the lane's clock domain and treats the line pins as oversampled inputs. The pins first pass through a two-flop synchronizer. A new line level counts only after it has stayed put for a programmable number of samples.

From the filtered line states the block recognises the escape entry pattern and drops back to Stop if the line returns to LP-11 too early. It then turns spaced-one-hot symbols into bits and collects the first eight bits as a command. The command selects one of three outcomes: low-power data reception, the ultra-low-power state, or a one-cycle trigger pulse. A code outside the table raises an error flag. In data mode every eight bits come out as a byte with a one-cycle valid strobe. LP-11 on the line returns the receiver to Stop from any escape activity.

Top module: `esc_lane_rx`

## Requirements
- R1: A line state is accepted only after the synchronized pins have shown it for at least `filt_len_i` consecutive samples, where a value of 0 counts as 1. A shorter excursion, such as a two-sample LP-11 while `filt_len_i` = 3, has no effect on any output.
- R2: Line states are written {dp_i, dn_i}, so LP-10 means dp_i=1 and dn_i=0. Escape entry is recognised only after the accepted states LP-11, LP-10, LP-00, LP-01, LP-00 occur in that order. `stop_o` falls after entry.
- R3: If LP-11 is accepted before the final LP-00 of the entry pattern, entry is abandoned. `stop_o` stays 1, and later marks and spaces produce no command, byte or trigger until a full entry pattern starts again from LP-11.
- R4: A bit is a Mark followed by Space (LP-00). Mark-1 is LP-10 and gives a one. Mark-0 is LP-01 and gives a zero. A Mark counts only when it is entered directly from Space. Space held for any length produces no bit.
- R5: After entry, the first eight bits form the command. The first bit received is the command's most significant bit. Command 11100001 raises `lpdt_o`.
- R6: Command 00011110 raises `ulps_o`. While it is high, marks and spaces on the line produce no byte and no trigger, and `ulps_o` stays high.
- R7: Commands 01100010, 01011101, 00100001 and 10100000 each produce exactly one single-cycle pulse, on `trig_o[0]`, `trig_o[1]`, `trig_o[2]` and `trig_o[3]` respectively.
- R8: Any other command sets `esc_err_o`. The flag holds until LP-11 is accepted, and further bits give no byte and no trigger in the meantime.
- R9: In data mode, every eight received bits produce one `rx_valid_o` pulse with the byte on `rx_byte_o`. The first bit of the eight lands in bit 0.
- R10: Accepting LP-11 in any escape mode returns the receiver to Stop. `stop_o` becomes 1, `lpdt_o`, `ulps_o` and `esc_err_o` become 0, and a partial byte is discarded.
- R11: After reset `stop_o` is 1, and `lpdt_o`, `ulps_o`, `esc_err_o`, `trig_o` and `rx_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, also the oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | Positive-wire low-power level (asynchronous) |
| dn_i | input | 1 | Negative-wire low-power level (asynchronous) |
| filt_len_i | input | FILT_W | Samples a line state must be stable before acceptance |
| stop_o | output | 1 | Receiver in Stop (no escape activity) |
| lpdt_o | output | 1 | Low-power data reception active |
| ulps_o | output | 1 | Ultra-low-power state entered |
| esc_err_o | output | 1 | Unknown escape command received |
| trig_o | output | 4 | One-cycle trigger pulses, one bit per trigger code |
| rx_byte_o | output | DATA_W | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |

## Verification
A corrupted command register or bit counter shows up at the outputs about filter-length plus four cycles after the eighth Mark. The symptom is a wrong mode flag, a missing or doubled trigger, or a byte with shifted bits. A stale entry-detector state is visible at the next LP-00 as `stop_o` falling when it should not. A stuck mode register shows as `stop_o` staying low after LP-11 has been held for the filter length. The sweep over all 256 command values, at two filter lengths, exposes every misclassified code within one command time.

// File: rtl/esc_rx_pkg.sv
package esc_rx_pkg;

  typedef logic [1:0] line_t;

  localparam line_t LN_11 = 2'b11;
  localparam line_t LN_10 = 2'b10;
  localparam line_t LN_01 = 2'b01;
  localparam line_t LN_00 = 2'b00;

  localparam int CMD_W    = 8;
  localparam int NUM_TRIG = 4;
  localparam int TRIG_IW  = $clog2(NUM_TRIG);

  typedef enum logic [1:0] {
    CL_DATA,
    CL_SLEEP,
    CL_TRIG,
    CL_BAD
  } cmd_class_e;

  typedef struct packed {
    cmd_class_e          cls;
    logic [TRIG_IW-1:0]  trig_idx;
  } cmd_dec_t;

  // Command classification; first received bit is the MSB.
  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_dec_t d;
    d.cls      = CL_BAD;
    d.trig_idx = '0;
    case (c)
      8'b1110_0001: d.cls = CL_DATA;
      8'b0001_1110: d.cls = CL_SLEEP;
      8'b0110_0010: begin d.cls = CL_TRIG; d.trig_idx = TRIG_IW'(0); end
      8'b0101_1101: begin d.cls = CL_TRIG; d.trig_idx = TRIG_IW'(1); end
      8'b0010_0001: begin d.cls = CL_TRIG; d.trig_idx = TRIG_IW'(2); end
      8'b1010_0000: begin d.cls = CL_TRIG; d.trig_idx = TRIG_IW'(3); end
      default:      d.cls = CL_BAD;
    endcase
    return d;
  endfunction

  function automatic logic is_mark(input line_t s);
    return (s == LN_10) || (s == LN_01);
  endfunction

  function automatic logic mark_value(input line_t s);
    return s == LN_10;
  endfunction

  // Saturating increment of a run-length counter.
  function automatic logic [15:0] run_inc(input logic [15:0] cnt, input logic [15:0] cap);
    return (cnt >= cap) ? cap : cnt + 16'd1;
  endfunction

endpackage

// File: rtl/esc_line_filter.sv
module esc_line_filter
  import esc_rx_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_i,
  input  logic              dn_i,
  input  logic [FILT_W-1:0] len_i,
  output line_t             state_o,
  output logic              evt_o
);

  localparam logic [15:0] RUN_CAP = 16'((1 << FILT_W) - 1);

  line_t             sync1, sync2, cand, acc;
  logic [FILT_W-1:0] run;
  logic [FILT_W-1:0] run_next;
  logic [FILT_W-1:0] need;
  logic              settle;

  always_comb begin
    need     = (len_i == '0) ? FILT_W'(1) : len_i;
    run_next = (sync2 == cand) ? FILT_W'(run_inc(16'(run), RUN_CAP)) : FILT_W'(1);
    settle   = (run_next >= need) && (acc != sync2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= LN_11;
      sync2 <= LN_11;
      cand  <= LN_11;
      acc   <= LN_11;
      run   <= '0;
      evt_o <= 1'b0;
    end else begin
      sync1 <= {dp_i, dn_i};
      sync2 <= sync1;
      cand  <= sync2;
      run   <= run_next;
      evt_o <= settle;
      if (settle) acc <= sync2;
    end
  end

  assign state_o = acc;

endmodule

// File: rtl/esc_entry_detect.sv
module esc_entry_detect
  import esc_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt_i,
  input  line_t state_i,
  output logic  entry_o,
  output logic  abort_o
);

  typedef enum logic [2:0] {E_IDLE, E_G10, E_G00, E_G01, E_HOLD} ent_e;

  ent_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      entry_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      entry_o <= 1'b0;
      abort_o <= 1'b0;
      if (evt_i) begin
        if (state_i == LN_11) begin
          abort_o <= (st == E_G10) || (st == E_G00) || (st == E_G01);
          st      <= E_IDLE;
        end else begin
          case (st)
            E_IDLE:  st <= (state_i == LN_10) ? E_G10 : E_HOLD;
            E_G10:   st <= (state_i == LN_00) ? E_G00 : E_HOLD;
            E_G00:   st <= (state_i == LN_01) ? E_G01 : E_HOLD;
            E_G01: begin
              entry_o <= (state_i == LN_00);
              st      <= E_HOLD;
            end
            default: st <= E_HOLD;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/esc_sot_decode.sv
module esc_sot_decode
  import esc_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt_i,
  input  line_t state_i,
  input  logic  en_i,
  output logic  bit_stb_o,
  output logic  bit_val_o
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      bit_stb_o <= 1'b0;
      bit_val_o <= 1'b0;
    end else begin
      bit_stb_o <= 1'b0;
      if (evt_i) begin
        armed     <= (state_i == LN_00);
        bit_stb_o <= en_i && armed && is_mark(state_i);
        bit_val_o <= mark_value(state_i);
      end
    end
  end

endmodule

// File: rtl/esc_lane_rx.sv
module esc_lane_rx
  import esc_rx_pkg::*;
#(
  parameter int FILT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dp_i,
  input  logic                dn_i,
  input  logic [FILT_W-1:0]   filt_len_i,
  output logic                stop_o,
  output logic                lpdt_o,
  output logic                ulps_o,
  output logic                esc_err_o,
  output logic [NUM_TRIG-1:0] trig_o,
  output logic [DATA_W-1:0]   rx_byte_o,
  output logic                rx_valid_o
);

  localparam int CNT_W = $clog2((DATA_W > CMD_W ? DATA_W : CMD_W) + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {M_STOP, M_CMD, M_DATA, M_SLEEP, M_HALT} mode_e;

  line_t             line_state;
  logic              line_evt;
  logic              entry_pulse;
  logic              abort_pulse;
  logic              bit_stb;
  logic              bit_val;
  logic              dec_en;
  logic              line_exit;
  mode_e             mode;
  logic [CMD_W-1:0]  cmd_sr;
  logic [CMD_W-1:0]  cmd_full;
  logic [DATA_W-1:0] data_sr;
  logic [DATA_W-1:0] data_full;
  logic [CNT_W-1:0]  bit_cnt;
  logic              err_q;
  cmd_dec_t          cmd_dec;

  esc_line_filter #(.FILT_W(FILT_W)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp_i    (dp_i),
    .dn_i    (dn_i),
    .len_i   (filt_len_i),
    .state_o (line_state),
    .evt_o   (line_evt)
  );

  esc_entry_detect u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (line_evt),
    .state_i (line_state),
    .entry_o (entry_pulse),
    .abort_o (abort_pulse)
  );

  esc_sot_decode u_sot (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (line_evt),
    .state_i   (line_state),
    .en_i      (dec_en),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val)
  );

  always_comb begin
    dec_en    = (mode == M_CMD) || (mode == M_DATA);
    line_exit = line_evt && (line_state == LN_11);
    cmd_full  = {cmd_sr[CMD_W-2:0], bit_val};
    data_full = {bit_val, data_sr[DATA_W-1:1]};
    cmd_dec   = decode_cmd(cmd_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_STOP;
      cmd_sr     <= '0;
      data_sr    <= '0;
      bit_cnt    <= '0;
      err_q      <= 1'b0;
      trig_o     <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      trig_o     <= '0;
      rx_valid_o <= 1'b0;
      if (line_exit) begin
        mode    <= M_STOP;
        err_q   <= 1'b0;
        bit_cnt <= '0;
      end else begin
        case (mode)
          M_STOP: begin
            if (entry_pulse) begin
              mode    <= M_CMD;
              bit_cnt <= '0;
            end
          end
          M_CMD: begin
            if (bit_stb) begin
              cmd_sr  <= cmd_full;
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (bit_cnt == CMD_LAST) begin
                bit_cnt <= '0;
                case (cmd_dec.cls)
                  CL_DATA:  mode <= M_DATA;
                  CL_SLEEP: mode <= M_SLEEP;
                  CL_TRIG: begin
                    mode   <= M_HALT;
                    trig_o <= NUM_TRIG'(1) << cmd_dec.trig_idx;
                  end
                  default: begin
                    mode  <= M_HALT;
                    err_q <= 1'b1;
                  end
                endcase
              end
            end
          end
          M_DATA: begin
            if (bit_stb) begin
              data_sr <= data_full;
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (bit_cnt == DATA_LAST) begin
                bit_cnt    <= '0;
                rx_byte_o  <= data_full;
                rx_valid_o <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stop_o    = (mode == M_STOP);
  assign lpdt_o    = (mode == M_DATA);
  assign ulps_o    = (mode == M_SLEEP);
  assign esc_err_o = err_q;

endmodule

// File: rtl/esc_lane_rx_checker.sv
module esc_lane_rx_checker
  import esc_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                line_evt,
  input line_t               line_state,
  input logic                entry_pulse,
  input logic                abort_pulse,
  input logic                stop_o,
  input logic                lpdt_o,
  input logic                ulps_o,
  input logic                esc_err_o,
  input logic [NUM_TRIG-1:0] trig_o,
  input logic                rx_valid_o
);

  a_r10_exit_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && line_state == LN_11) |=> stop_o);

  a_r10_stop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!lpdt_o && !ulps_o && !esc_err_o));

  a_r2_entry_leaves_stop: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |=> !stop_o);

  a_r3_abort_stays_stop: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> stop_o);

  a_r7_trig_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_o));

  a_r7_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o != '0) |=> (trig_o == '0));

  a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_err_o && !(line_evt && line_state == LN_11)) |=> esc_err_o);

  a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    esc_err_o |-> (trig_o == '0 && !rx_valid_o));

  a_r6_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ulps_o |-> (trig_o == '0 && !rx_valid_o));

  a_r9_valid_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> lpdt_o);

endmodule

bind esc_lane_rx esc_lane_rx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_evt    (line_evt),
  .line_state  (line_state),
  .entry_pulse (entry_pulse),
  .abort_pulse (abort_pulse),
  .stop_o      (stop_o),
  .lpdt_o      (lpdt_o),
  .ulps_o      (ulps_o),
  .esc_err_o   (esc_err_o),
  .trig_o      (trig_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/esc_lane_rx_test.sv
`timescale 1ns/1ps
module esc_lane_rx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b1, dn = 1'b1;
  logic [3:0] flen = 4'd1;
  logic       stop_o, lpdt_o, ulps_o, esc_err_o, rx_valid_o;
  logic [3:0] trig_o;
  logic [7:0] rx_byte_o;

  int checks = 0;
  int errors = 0;
  int hold = 6;
  int nbytes = 0;
  int tcnt [4];
  logic [7:0] bytes [0:31];

  always #2 clk = ~clk;

  esc_lane_rx uut (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dn_i(dn), .filt_len_i(flen),
    .stop_o(stop_o), .lpdt_o(lpdt_o), .ulps_o(ulps_o), .esc_err_o(esc_err_o),
    .trig_o(trig_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o) begin
        if (nbytes < 32) bytes[nbytes] = rx_byte_o;
        nbytes++;
      end
      for (int i = 0; i < 4; i++) if (trig_o[i]) tcnt[i]++;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clear_obs();
    nbytes = 0;
    for (int i = 0; i < 4; i++) tcnt[i] = 0;
  endtask

  task automatic drive(input logic [1:0] s, input int n);
    @(negedge clk);
    {dp, dn} = s;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_entry();
    drive(2'b11, hold);
    drive(2'b10, hold);
    drive(2'b00, hold);
    drive(2'b01, hold);
    drive(2'b00, hold);
  endtask

  task automatic send_bit(input logic b);
    drive(b ? 2'b10 : 2'b01, hold);
    drive(2'b00, hold);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
  endtask

  // {data, sleep, err, t3, t2, t1, t0, bytes}
  function automatic logic [7:0] exp_class(input logic [7:0] c);
    case (c)
      8'hE1:   return 8'b1000_0000;
      8'h1E:   return 8'b0100_0000;
      8'h62:   return 8'b0000_0010;
      8'h5D:   return 8'b0000_0100;
      8'h21:   return 8'b0000_1000;
      8'hA0:   return 8'b0001_0000;
      default: return 8'b0010_0000;
    endcase
  endfunction

  function automatic logic [7:0] obs_class();
    return {lpdt_o, ulps_o, esc_err_o, tcnt[3] == 1, tcnt[2] == 1,
            tcnt[1] == 1, tcnt[0] == 1, nbytes != 0};
  endfunction

  initial begin
    #(4ns * 195000);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_obs();
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {stop_o, lpdt_o, ulps_o, esc_err_o, trig_o, rx_valid_o},
          {1'b1, 1'b0, 1'b0, 1'b0, 4'b0, 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 R6 R7 R8 R10: sweep all commands at two filter lengths
    for (int l = 1; l <= 3; l += 2) begin
      flen = 4'(l);
      hold = l + 5;
      for (int c = 0; c < 256; c++) begin
        clear_obs();
        send_entry();
        check("R2 entry", stop_o, 1'b0);
        send_cmd(8'(c));
        drive(2'b00, hold);
        check($sformatf("R5 R6 R7 R8 cmd %02h", c), obs_class(), exp_class(8'(c)));
        drive(2'b11, hold);
        check("R10 exit", {stop_o, lpdt_o, ulps_o, esc_err_o}, 4'b1000);
      end
    end

    // R9 data bytes with pauses, R4 spaces produce no bits
    flen = 4'd2;
    hold = 7;
    clear_obs();
    send_entry();
    send_cmd(8'hE1);
    check("R5 data mode", lpdt_o, 1'b1);
    send_byte(8'h00);
    send_byte(8'hFF);
    drive(2'b00, hold * 5);
    send_byte(8'hA5);
    for (int i = 0; i < 8; i++) begin
      send_bit(i[0] ^ i[1]);
      drive(2'b00, hold * 2);
    end
    check("R9 byte count", nbytes, 4);
    check("R9 byte 0", bytes[0], 8'h00);
    check("R9 byte 1", bytes[1], 8'hFF);
    check("R9 byte 2", bytes[2], 8'hA5);
    check("R4 R9 byte 3", bytes[3], 8'h66);

    // R4 mark entered from mark gives no bit
    drive(2'b10, hold);
    drive(2'b01, hold);
    drive(2'b00, hold);
    for (int i = 1; i < 8; i++) send_bit(1'b0);
    check("R4 adjacent marks count", nbytes, 5);
    check("R4 adjacent marks byte", bytes[4], 8'h01);

    // R10 partial byte discarded at exit
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    drive(2'b10, hold);
    drive(2'b11, hold);
    check("R10 partial discarded", nbytes, 5);
    check("R10 stop after data", {stop_o, lpdt_o}, 2'b10);

    // R10 data after fresh entry starts a new byte
    send_entry();
    send_cmd(8'hE1);
    send_byte(8'h3C);
    check("R10 fresh byte", bytes[5], 8'h3C);
    drive(2'b11, hold);

    // R1 short LP-11 glitch ignored at filter length 3
    flen = 4'd3;
    hold = 8;
    clear_obs();
    send_entry();
    send_cmd(8'hE1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    drive(2'b11, 2);
    drive(2'b00, hold);
    check("R1 glitch keeps data mode", {stop_o, lpdt_o}, 2'b01);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    check("R1 byte after glitch", {24'(nbytes), bytes[0]}, {24'd1, 8'h0F});
    drive(2'b11, hold);
    check("R1 long LP-11 accepted", stop_o, 1'b1);

    // R6 ULPS ignores marks
    clear_obs();
    send_entry();
    send_cmd(8'h1E);
    send_cmd(8'hE1);
    send_byte(8'h55);
    check("R6 sleep silent", {ulps_o, 24'(nbytes), tcnt[0][3:0]}, {1'b1, 24'd0, 4'd0});
    drive(2'b11, hold);
    check("R6 sleep exit", {stop_o, ulps_o}, 2'b10);

    // R8 error suppresses decoding
    clear_obs();
    send_entry();
    send_cmd(8'hFF);
    send_cmd(8'h62);
    send_byte(8'h12);
    check("R8 error holds and silent", {esc_err_o, 24'(nbytes), tcnt[0][3:0]},
          {1'b1, 24'd0, 4'd0});
    drive(2'b11, hold);
    check("R8 error cleared by stop", esc_err_o, 1'b0);

    // R3 abort at two stages
    clear_obs();
    drive(2'b10, hold);
    drive(2'b00, hold);
    drive(2'b11, hold);
    drive(2'b01, hold);
    drive(2'b00, hold);
    check("R3 abort after LP-00", stop_o, 1'b1);
    send_cmd(8'h62);
    send_cmd(8'hE1);
    send_byte(8'hAA);
    check("R3 no decode after abort", {stop_o, lpdt_o, 24'(nbytes), tcnt[0][3:0]},
          {1'b1, 1'b0, 24'd0, 4'd0});
    drive(2'b11, hold);
    drive(2'b10, hold);
    drive(2'b00, hold);
    drive(2'b01, hold);
    drive(2'b11, hold);
    drive(2'b00, hold);
    check("R3 abort after LP-01", stop_o, 1'b1);
    drive(2'b11, hold);
    send_entry();
    send_cmd(8'h62);
    drive(2'b00, hold);
    check("R3 recovery trigger", {stop_o, tcnt[0][3:0]}, {1'b0, 4'd1});
    drive(2'b11, hold);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule